// File: doc/BRIEF.md
# Programmable Frame-Sync Pulse Generator

This block makes the periodic frame-sync pulse that a synchronous serial audio port needs. It runs on a single clock. A bit-clock enable strobe advances it by one bit position. A frame lasts a programmable number of bit positions, and the pulse stays active for a programmable number of bit positions at the start of each frame. Both numbers are written as count-minus-one fields. The pulse is driven on two lines, one for the transmit serializer and one for the receive serializer, and each line has its own polarity. A third output is a one-clock frame-start strobe that marks the first active bit of every pulse.

Two enables bring the block up in order. The sample generator enable comes first. The frame-sync enable has an effect only once the sample generator is already running. The period, width and polarity inputs are captured continuously while frame sync is stopped and are held fixed while it runs. A new setting therefore needs a stop and a restart. Dropping either enable stops the generator and parks both lines at their inactive level.

Top module: `framesync_gen`

## Requirements
- R1: While reset is asserted and after it is released, with both enables low, both frame-sync lines sit at their inactive level and frameStart is 0. After reset both polarity settings are 0, so both lines are low.
- R2: While running, a frame lasts periodCfg+1 bit-enable strobes. frameStart goes high exactly once per frame, on the first bit of the frame. With periodCfg=0 every bit is a frame start.
- R3: The pulse is active from the first bit of the frame for widthCfg+1 bit-enable strobes, when widthCfg < periodCfg. With periodCfg=31 and widthCfg=15 this gives a 32-bit frame with 16 active bits.
- R4: When widthCfg >= periodCfg and periodCfg >= 1, the pulse is clamped to periodCfg active bits, so the line goes inactive for exactly one bit per frame. With periodCfg=0 the line stays active.
- R5: Each line has its own polarity input, txPolarity or rxPolarity. A value of 1 makes that line active-low, so it idles high. A value of 0 makes it active-high, so it idles low.
- R6: Frame sync runs from the clock edge after fsEnable is seen high while the sample generator is running. The sample generator is running from the clock edge after sgEnable is seen high. The first bit-enable strobe sampled while running is the first bit of the first frame.
- R7: With sgEnable low, fsEnable produces no pulses and no frameStart, and the lines stay at their inactive level.
- R8: When fsEnable or sgEnable is sampled low, both lines are at their inactive level and frameStart is 0 from the second clock edge onward. The next start begins a fresh frame at bit 0.
- R9: periodCfg, widthCfg and both polarity inputs are captured only while frame sync is stopped. Changes made while it runs have no effect on the output until the next restart.
- R10: frameStart is high for a single clock after the edge that sampled the strobe, unless the next strobe also starts a frame.
- R11: While running, a clock with bitEn low leaves the lines and the bit position unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitEn | input | 1 | Bit-clock enable strobe, one clock per bit |
| sgEnable | input | 1 | Sample generator enable, active high |
| fsEnable | input | 1 | Frame-sync generator enable, active high |
| periodCfg | input | 12 | Bits per frame minus one |
| widthCfg | input | 8 | Active pulse bits minus one |
| txPolarity | input | 1 | 1 = transmit line active-low |
| rxPolarity | input | 1 | 1 = receive line active-low |
| txFs | output | 1 | Transmit frame-sync line |
| rxFs | output | 1 | Receive frame-sync line |
| frameStart | output | 1 | One-clock strobe on the first active bit of each pulse |

## Verification
The bench aims at the width clamp, both with a width field equal to the period field and with one above it. A design that clamps wrongly would either hold the line active for the whole frame or end the pulse one bit too early. It raises fsEnable while the sample generator is off, where a design with a broken gate would emit pulses. It also changes the configuration in the middle of a run, where a design that fails to freeze its shadow copy would change the frame length partway through. It drives irregular bit-enable patterns and a one-bit frame, which expose a counter that advances on clocks with no strobe or that cannot wrap at zero. It then checks the idle level after each stop under mixed polarities.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  // Strobes from the control sequencer to the datapath
  typedef struct packed {
    logic load;   // capture configuration into shadow registers
    logic clear;  // hold counter and pulse at idle
    logic step;   // advance one bit position
  } fsgCtl_t;

endpackage

// File: rtl/fsg_ctrl.sv
module fsg_ctrl
  import fsg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    bitEn,
  input  logic    sgEnable,
  input  logic    fsEnable,
  output fsgCtl_t ctl
);

  logic sgActive;
  logic fsActive;

  // The sample generator follows its enable one edge later. Frame sync
  // may run only while the sample generator was already active and is
  // still enabled.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sgActive <= 1'b0;
      fsActive <= 1'b0;
    end else begin
      sgActive <= sgEnable;
      fsActive <= fsEnable & sgEnable & sgActive;
    end
  end

  always_comb begin
    ctl.load  = ~fsActive;
    ctl.clear = ~fsActive;
    ctl.step  = fsActive & bitEn;
  end

endmodule

// File: rtl/fsg_datapath.sv
module fsg_datapath
  import fsg_pkg::*;
#(
  parameter int PERIOD_W = 12,
  parameter int WIDTH_W  = 8,
  parameter int LINES    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  fsgCtl_t             ctl,
  input  logic [PERIOD_W-1:0] periodCfg,
  input  logic [WIDTH_W-1:0]  widthCfg,
  input  logic [LINES-1:0]    linePol,
  output logic                pulseOn,
  output logic                frameStart,
  output logic [LINES-1:0]    linePolQ
);

  logic [PERIOD_W-1:0] periodQ;
  logic [PERIOD_W-1:0] lastActiveQ;
  logic [PERIOD_W-1:0] lastActiveNext;
  logic [PERIOD_W-1:0] widthExt;
  logic [PERIOD_W-1:0] bitPos;
  logic                frameEnd;

  // Clamp the width against the period before it is stored, so the
  // running comparison sees one ready operand
  always_comb begin
    widthExt = PERIOD_W'(widthCfg);
    if (periodCfg == '0)
      lastActiveNext = '0;
    else if (widthExt >= periodCfg)
      lastActiveNext = periodCfg - 1'b1;
    else
      lastActiveNext = widthExt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodQ     <= '0;
      lastActiveQ <= '0;
      linePolQ    <= '0;
    end else if (ctl.load) begin
      periodQ     <= periodCfg;
      lastActiveQ <= lastActiveNext;
      linePolQ    <= linePol;
    end
  end

  assign frameEnd = (bitPos == periodQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitPos     <= '0;
      pulseOn    <= 1'b0;
      frameStart <= 1'b0;
    end else if (ctl.clear) begin
      bitPos     <= '0;
      pulseOn    <= 1'b0;
      frameStart <= 1'b0;
    end else if (ctl.step) begin
      pulseOn    <= (bitPos <= lastActiveQ);
      frameStart <= (bitPos == '0);
      bitPos     <= frameEnd ? '0 : bitPos + 1'b1;
    end else begin
      frameStart <= 1'b0;
    end
  end

endmodule

// File: rtl/framesync_gen.sv
module framesync_gen
  import fsg_pkg::*;
#(
  parameter int PERIOD_W = 12,
  parameter int WIDTH_W  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitEn,
  input  logic                sgEnable,
  input  logic                fsEnable,
  input  logic [PERIOD_W-1:0] periodCfg,
  input  logic [WIDTH_W-1:0]  widthCfg,
  input  logic                txPolarity,
  input  logic                rxPolarity,
  output logic                txFs,
  output logic                rxFs,
  output logic                frameStart
);

  localparam int LINES = 2;

  fsgCtl_t          ctl;
  logic             pulseOn;
  logic [LINES-1:0] linePol;
  logic [LINES-1:0] linePolQ;
  logic [LINES-1:0] lineOut;

  assign linePol = {rxPolarity, txPolarity};

  fsg_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bitEn    (bitEn),
    .sgEnable (sgEnable),
    .fsEnable (fsEnable),
    .ctl      (ctl)
  );

  fsg_datapath #(
    .PERIOD_W (PERIOD_W),
    .WIDTH_W  (WIDTH_W),
    .LINES    (LINES)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .periodCfg  (periodCfg),
    .widthCfg   (widthCfg),
    .linePol    (linePol),
    .pulseOn    (pulseOn),
    .frameStart (frameStart),
    .linePolQ   (linePolQ)
  );

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign lineOut[g] = pulseOn ^ linePolQ[g];
  end

  assign txFs = lineOut[0];
  assign rxFs = lineOut[1];

endmodule

// File: rtl/framesync_gen_chk.sv
module framesync_gen_chk
  import fsg_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    sgEnable,
  input logic    frameStart,
  input logic    pulseOn,
  input fsgCtl_t ctl
);

  // R10
  start_needs_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> $past(ctl.step));

  // R3
  start_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> pulseOn);

  // R8
  idle_after_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.clear) |-> (!pulseOn && !frameStart));

  // R7
  sg_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |-> $past(sgEnable));

  // R11
  hold_without_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(ctl.step) && !$past(ctl.clear)) |-> $stable(pulseOn));

endmodule

bind framesync_gen framesync_gen_chk i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sgEnable   (sgEnable),
  .frameStart (frameStart),
  .pulseOn    (pulseOn),
  .ctl        (ctl)
);

// File: tb/test_framesync_gen.sv
`timescale 1ns/1ps
module test_framesync_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitEn = 1'b0;
  logic        sgEnable = 1'b0;
  logic        fsEnable = 1'b0;
  logic [11:0] periodCfg = 12'd31;
  logic [7:0]  widthCfg = 8'd15;
  logic        txPolarity = 1'b0;
  logic        rxPolarity = 1'b0;
  logic        txFs;
  logic        rxFs;
  logic        frameStart;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // expected state
  int  ePos;
  int  eLast;
  int  eP;
  bit  ePulse;
  bit  eStart;
  bit  eTx;
  bit  eRx;

  always #2.5 clk = ~clk;

  framesync_gen i_framesync_gen (
    .clk        (clk),
    .rstN       (rstN),
    .bitEn      (bitEn),
    .sgEnable   (sgEnable),
    .fsEnable   (fsEnable),
    .periodCfg  (periodCfg),
    .widthCfg   (widthCfg),
    .txPolarity (txPolarity),
    .rxPolarity (rxPolarity),
    .txFs       (txFs),
    .rxFs       (rxFs),
    .frameStart (frameStart)
  );

  function automatic int lastActive(int p, int w);
    if (p == 0) return 0;
    if (w >= p) return p - 1;
    return w;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkLines(string req);
    check(txFs == (ePulse ^ eTx), {req, " txFs"}, txFs, ePulse ^ eTx);
    check(rxFs == (ePulse ^ eRx), {req, " rxFs"}, rxFs, ePulse ^ eRx);
    check(frameStart == eStart, {req, " frameStart"}, frameStart, eStart);
  endtask

  task automatic stepModel(bit en);
    if (en) begin
      eStart = (ePos == 0);
      ePulse = (ePos <= eLast);
      ePos   = (ePos == eP) ? 0 : ePos + 1;
    end else begin
      eStart = 1'b0;
    end
  endtask

  // enRate: bitEn high with probability enRate/4; change: disturb cfg mid-run
  task automatic runCase(int p, int w, bit tp, bit rp, int cycles, int enRate,
                         bit change, bit stopBySg, string req);
    int starts;
    int expStarts;
    @(negedge clk);
    periodCfg  = 12'(p);
    widthCfg   = 8'(w);
    txPolarity = tp;
    rxPolarity = rp;
    sgEnable   = 1'b1;
    repeat (2) @(negedge clk);
    eP = p; eLast = lastActive(p, w); eTx = tp; eRx = rp;
    ePos = 0; ePulse = 0; eStart = 0;
    check(txFs == tp && rxFs == rp && !frameStart, "R5 idle level", {30'd0, txFs, rxFs}, {30'd0, tp, rp});
    fsEnable = 1'b1;
    bitEn    = 1'b1;               // R6: strobe on the enabling edge is ignored
    @(posedge clk);
    starts = 0;
    expStarts = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      checkLines(req);
      if (frameStart) starts++;
      if (eStart) expStarts++;
      if (change && c == cycles / 2) begin
        periodCfg  = 12'($urandom_range(0, 60));   // R9: must be ignored
        widthCfg   = 8'($urandom_range(0, 60));
        txPolarity = ~tp;
        rxPolarity = ~rp;
      end
      bitEn = ($urandom_range(0, 3) < enRate);
      @(posedge clk);
      stepModel(bitEn);
    end
    check(starts == expStarts, "R2 frame count", starts, expStarts);
    // stop sequence
    @(negedge clk);
    checkLines(req);
    if (change) begin
      txPolarity = tp;
      rxPolarity = rp;
    end
    if (stopBySg) sgEnable = 1'b0;
    else fsEnable = 1'b0;
    bitEn = 1'b1;
    @(posedge clk);
    stepModel(1'b1);
    @(negedge clk);
    checkLines("R8 last bit");
    @(negedge clk);
    check(txFs == tp, "R8 tx idle after stop", txFs, tp);
    check(rxFs == rp, "R8 rx idle after stop", rxFs, rp);
    check(!frameStart, "R8 no start after stop", frameStart, 0);
    bitEn = 1'b0;
    fsEnable = 1'b0;
    sgEnable = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd7413));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(txFs == 0 && rxFs == 0 && frameStart == 0, "R1 during reset",
          {29'd0, txFs, rxFs, frameStart}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(txFs == 0 && rxFs == 0 && frameStart == 0, "R1 after reset",
          {29'd0, txFs, rxFs, frameStart}, 0);

    // R6: first start on first strobe after running
    @(negedge clk);
    periodCfg = 12'd7; widthCfg = 8'd2; sgEnable = 1'b1;
    repeat (2) @(negedge clk);
    fsEnable = 1'b1; bitEn = 1'b1;
    @(negedge clk);
    check(frameStart == 0 && txFs == 0, "R6 no start on enabling edge", frameStart, 0);
    @(negedge clk);
    check(frameStart == 1 && txFs == 1, "R6 start on first strobe", frameStart, 1);
    @(negedge clk);
    check(frameStart == 0, "R10 strobe one clock", frameStart, 0);
    fsEnable = 1'b0; sgEnable = 1'b0; bitEn = 1'b0;
    repeat (3) @(negedge clk);

    // R3: default 16-bit layout, continuous strobes
    runCase(31, 15, 0, 0, 200, 4, 0, 0, "R3 default 32/16");
    // R4: clamp equal and above
    runCase(5, 5, 0, 0, 100, 4, 0, 0, "R4 clamp equal");
    runCase(5, 200, 0, 1, 100, 3, 0, 1, "R4 clamp above");
    // R2: one-bit frame
    runCase(0, 9, 0, 0, 50, 4, 0, 0, "R2 period zero");
    // R5: mixed polarity
    runCase(9, 3, 1, 0, 120, 2, 0, 0, "R5 tx active-low");
    runCase(9, 3, 0, 1, 120, 2, 0, 1, "R5 rx active-low");
    // R9: config changes while running
    runCase(12, 4, 0, 0, 200, 3, 1, 0, "R9 cfg frozen");
    // R11: sparse strobes
    runCase(6, 2, 1, 1, 200, 1, 0, 0, "R11 sparse strobes");

    // R7: frame-sync enable without sample generator
    @(negedge clk);
    txPolarity = 1'b1; rxPolarity = 1'b0; periodCfg = 12'd3; widthCfg = 8'd0;
    fsEnable = 1'b1; bitEn = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      check(frameStart == 0, "R7 no start without sg", frameStart, 0);
      check(txFs == 1 && rxFs == 0, "R7 lines idle without sg",
            {30'd0, txFs, rxFs}, 2);
    end
    fsEnable = 1'b0; bitEn = 1'b0;
    txPolarity = 1'b0;
    repeat (2) @(negedge clk);

    // random mix
    for (int k = 0; k < 10; k++) begin
      runCase($urandom_range(1, 40), $urandom_range(0, 50),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              300, $urandom_range(1, 4), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), "R2 R3 random");
    end

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule